// File: doc/BRIEF.md
# Machine-Level Interrupt Trap Arbiter

This block decides, once per clock, whether a pending interrupt must cause a trap into machine mode and which cause number that trap reports. It receives the interrupt pending vector, the enable vector, the delegation mask, the current privilege mode and the global machine interrupt enable bit. A cause is live when it is pending, enabled and not delegated. Live causes are admitted only when the hart runs below machine mode, or runs in machine mode with the global enable set. Among admitted causes, platform causes (bit 16 and up) win first, then the standard causes in a fixed order that is not numeric.

The decision is registered. The core pipeline also tells the arbiter when a return-from-trap or an explicit write to an interrupt-related register is in flight. During that cycle the sampled inputs may still hold old values, so the arbiter withholds the trap for one cycle. At the next edge it evaluates the updated state. Causes that do not carry a defined machine-level meaning never produce a trap. The non-maskable interrupt does not pass through this block.

Top module: `irq_trap_arbiter`

## Requirements
- R1: A cause bit i is live only when pend_i[i], en_i[i] are both 1 and deleg_i[i] is 0; any cause failing one of these never produces a trap.
- R2: Privilege encoding is 2'b11 machine, 2'b01 supervisor, 2'b00 user (2'b10 is treated as below machine). Live causes trap when priv_i is not 2'b11, or when priv_i is 2'b11 and mstatus_mie_i is 1; in machine mode with mstatus_mie_i at 0 no trap is taken.
- R3: Among live standard causes the winner follows this order, highest first: bit 11, bit 3, bit 7, bit 9, bit 1, bit 5, bit 13.
- R4: Any live cause at bit 16 or above beats every standard cause; among several of them the lowest bit number wins.
- R5: Standard bits 0, 2, 4, 6, 8, 10, 12, 14 and 15 never produce a trap, even when live.
- R6: trap_o and cause_o are registered: they reflect the inputs sampled at the previous rising clock edge, and input changes between edges do not alter them.
- R7: If xret_i or csr_wr_i is 1 at a rising edge, trap_o and cause_o are 0 after that edge; the next edge without a pulse evaluates the inputs present at that edge.
- R8: When no cause is admitted, trap_o is 0 and cause_o is 0.
- R9: A synchronous reset (rst high at a rising edge) clears trap_o and cause_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_CAUSES | Interrupt pending vector |
| en_i | input | NUM_CAUSES | Interrupt enable vector |
| deleg_i | input | NUM_CAUSES | Delegation mask; a set bit routes the cause away from machine mode |
| priv_i | input | 2 | Current privilege mode |
| mstatus_mie_i | input | 1 | Global machine interrupt enable |
| xret_i | input | 1 | Pulse: trap return in flight |
| csr_wr_i | input | 1 | Pulse: write to an interrupt-related register in flight |
| trap_o | output | 1 | Registered trap request into machine mode |
| cause_o | output | CAUSE_W | Registered winning cause number, 0 when no trap |

## Verification
A vector table drives single causes through the pending, enable and delegation masks to separate each gating term. It also sweeps the privilege modes with the global enable off, which tells the machine-mode gate apart from the lower-mode bypass. Nested sets of standard causes, each set dropping the current winner, walk the full priority chain so that a numeric-order picker would be caught. Mixed platform and standard sets, and vectors built only from unranked bits, check the platform precedence and the filter. Directed sequences then cover reset, the one-cycle latency and the withhold after a trap-return or register-write pulse.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    localparam int PLAT_BASE   = 16;
    localparam int STD_COUNT   = 7;
    localparam int PICK_W      = 8;

    localparam int C_SSI   = 1;
    localparam int C_MSI   = 3;
    localparam int C_STI   = 5;
    localparam int C_MTI   = 7;
    localparam int C_SEI   = 9;
    localparam int C_MEI   = 11;
    localparam int C_LCOFI = 13;

    typedef struct packed {
        logic              found;
        logic [PICK_W-1:0] cause;
    } pick_t;

    // Standard cause occupying a given rank, rank 0 being the strongest.
    function automatic int std_order(input int rank);
        case (rank)
            0:       return C_MEI;
            1:       return C_MSI;
            2:       return C_MTI;
            3:       return C_SEI;
            4:       return C_SSI;
            5:       return C_STI;
            default: return C_LCOFI;
        endcase
    endfunction

    // True for cause numbers that may ever produce a machine trap.
    function automatic bit is_ranked(input int idx);
        if (idx >= PLAT_BASE) return 1'b1;
        for (int r = 0; r < STD_COUNT; r++) begin
            if (std_order(r) == idx) return 1'b1;
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/irq_live_mask.sv
module irq_live_mask
    import irq_arb_pkg::*;
#(
    parameter int NUM_CAUSES = 32
) (
    input  logic [NUM_CAUSES-1:0] pend_i,
    input  logic [NUM_CAUSES-1:0] en_i,
    input  logic [NUM_CAUSES-1:0] deleg_i,
    output logic [NUM_CAUSES-1:0] live_o
);

    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_bit
        if (is_ranked(g)) begin : g_ranked
            // R1: pending, enabled and kept at machine level
            assign live_o[g] = pend_i[g] & en_i[g] & ~deleg_i[g];
        end else begin : g_unranked
            // R5: no defined machine-level meaning, forced off
            assign live_o[g] = pend_i[g] & en_i[g] & ~deleg_i[g] & 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_CAUSES = 32
) (
    input  logic [NUM_CAUSES-1:0] live_i,
    output pick_t                 pick_o
);

    always_comb begin
        pick_o = '0;
        // R4: platform causes first, lowest index wins
        for (int i = PLAT_BASE; i < NUM_CAUSES; i++) begin
            if (!pick_o.found && live_i[i]) begin
                pick_o.found = 1'b1;
                pick_o.cause = PICK_W'(i);
            end
        end
        // R3: fixed order among standard causes
        for (int r = 0; r < STD_COUNT; r++) begin
            if (!pick_o.found && live_i[std_order(r)]) begin
                pick_o.found = 1'b1;
                pick_o.cause = PICK_W'(std_order(r));
            end
        end
    end

endmodule

// File: rtl/irq_trap_arbiter.sv
module irq_trap_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_CAUSES = 32,
    localparam int CAUSE_W   = $clog2(NUM_CAUSES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CAUSES-1:0] pend_i,
    input  logic [NUM_CAUSES-1:0] en_i,
    input  logic [NUM_CAUSES-1:0] deleg_i,
    input  logic [1:0]            priv_i,
    input  logic                  mstatus_mie_i,
    input  logic                  xret_i,
    input  logic                  csr_wr_i,
    output logic                  trap_o,
    output logic [CAUSE_W-1:0]    cause_o
);

    logic [NUM_CAUSES-1:0] live_w;
    pick_t                 pick_w;
    logic                  admit_w;
    logic                  trap_q;
    logic [CAUSE_W-1:0]    cause_q;

    irq_live_mask #(.NUM_CAUSES(NUM_CAUSES)) live_i (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .live_o  (live_w)
    );

    irq_prio_pick #(.NUM_CAUSES(NUM_CAUSES)) pick_i (
        .live_i (live_w),
        .pick_o (pick_w)
    );

    // R2: global gate from privilege mode and machine enable
    assign admit_w = (priv_e'(priv_i) != PRIV_M) || mstatus_mie_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q  <= 1'b0;
            cause_q <= '0;
        end else if (xret_i || csr_wr_i) begin
            // R7: inputs may be stale this cycle, hold off one cycle
            trap_q  <= 1'b0;
            cause_q <= '0;
        end else if (pick_w.found && admit_w) begin
            trap_q  <= 1'b1;
            cause_q <= pick_w.cause[CAUSE_W-1:0];
        end else begin
            trap_q  <= 1'b0;
            cause_q <= '0;
        end
    end

    assign trap_o  = trap_q;
    assign cause_o = cause_q;

    // Checker-side copy of the raw live condition from the ports.
    logic [NUM_CAUSES-1:0] raw_live_q;
    always_ff @(posedge clk) raw_live_q <= pend_i & en_i & ~deleg_i;

    assert_cause_live_R1: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> raw_live_q[cause_o]);

    assert_priv_gate_R2: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ($past(priv_i) != 2'b11 || $past(mstatus_mie_i)));

    assert_mti_below_mei_msi_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_o && cause_o == CAUSE_W'(C_MTI)) |->
            (!raw_live_q[C_MEI] && !raw_live_q[C_MSI]));

    assert_ranked_only_R5: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> is_ranked(int'(cause_o)));

    assert_pulse_withhold_R7: assert property (@(posedge clk) disable iff (rst)
        (xret_i || csr_wr_i) |=> !trap_o);

    assert_idle_cause_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> cause_o == '0);

endmodule

// File: tb/irq_trap_arbiter_tb_top.sv
module irq_trap_arbiter_tb_top;

    localparam int N  = 32;
    localparam int CW = 5;

    typedef struct packed {
        logic [N-1:0]  pend;
        logic [N-1:0]  en;
        logic [N-1:0]  deleg;
        logic [1:0]    priv;
        logic          mie;
        logic          take;
        logic [CW-1:0] cause;
        logic [3:0]    req;
    } vec_t;

    localparam logic [N-1:0] ALL = 32'hFFFF_FFFF;
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, ALL, 32'h0, 2'b11, 1'b1, 1'b0, 5'd0,  4'd8}, // R8 nothing pending
        '{32'h0000_0080, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd7,  4'd1}, // R1 single cause
        '{32'h0000_0080, 32'hFFFF_FF7F, 32'h0, 2'b11, 1'b1, 1'b0, 5'd0, 4'd1}, // R1 disabled
        '{32'h0000_0080, ALL, 32'h80, 2'b11, 1'b1, 1'b0, 5'd0, 4'd1}, // R1 delegated
        '{32'h0000_0080, ALL, 32'h0, 2'b11, 1'b0, 1'b0, 5'd0,  4'd2}, // R2 M, global off
        '{32'h0000_0080, ALL, 32'h0, 2'b01, 1'b0, 1'b1, 5'd7,  4'd2}, // R2 S mode
        '{32'h0000_0080, ALL, 32'h0, 2'b00, 1'b0, 1'b1, 5'd7,  4'd2}, // R2 U mode
        '{32'h0000_2AAA, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd11, 4'd3}, // R3 all standard
        '{32'h0000_22AA, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd3,  4'd3}, // R3
        '{32'h0000_22A2, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd7,  4'd3}, // R3
        '{32'h0000_2222, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd9,  4'd3}, // R3
        '{32'h0000_2022, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd1,  4'd3}, // R3
        '{32'h0000_2020, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd5,  4'd3}, // R3
        '{32'h0000_2000, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd13, 4'd3}, // R3 lowest rank
        '{32'h000A_2AAA, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd17, 4'd4}, // R4 platform wins
        '{32'hFFFF_D555, ALL, 32'hFFFF_0000, 2'b11, 1'b1, 1'b0, 5'd0, 4'd5}, // R5 unranked only
        '{32'h0000_8020, ALL, 32'h0, 2'b11, 1'b1, 1'b1, 5'd5,  4'd5}, // R5 bit15 ignored
        '{32'h0000_0808, ALL, 32'h800, 2'b11, 1'b1, 1'b1, 5'd3, 4'd1}  // R1 delegated MEI
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pend_i = '0;
    logic [N-1:0]  en_i = '0;
    logic [N-1:0]  deleg_i = '0;
    logic [1:0]    priv_i = 2'b11;
    logic          mstatus_mie_i = 1'b0;
    logic          xret_i = 1'b0;
    logic          csr_wr_i = 1'b0;
    logic          trap_o;
    logic [CW-1:0] cause_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_trap_arbiter #(.NUM_CAUSES(N)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .pend_i        (pend_i),
        .en_i          (en_i),
        .deleg_i       (deleg_i),
        .priv_i        (priv_i),
        .mstatus_mie_i (mstatus_mie_i),
        .xret_i        (xret_i),
        .csr_wr_i      (csr_wr_i),
        .trap_o        (trap_o),
        .cause_o       (cause_o)
    );

    task automatic check(input string tag, input logic exp_take, input logic [CW-1:0] exp_cause);
        checks++;
        if (trap_o !== exp_take || cause_o !== exp_cause) begin
            fails++;
            $display("FAIL %s: trap=%0b cause=%0d expected trap=%0b cause=%0d",
                     tag, trap_o, cause_o, exp_take, exp_cause);
        end
    endtask

    task automatic drive(input vec_t v);
        pend_i        = v.pend;
        en_i          = v.en;
        deleg_i       = v.deleg;
        priv_i        = v.priv;
        mstatus_mie_i = v.mie;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 reset", 1'b0, '0);
        rst = 1'b0;

        // Table walk: drive at negedge, one register, check next negedge
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].take, VECS[k].cause);
        end

        // R6: change between edges does not move the outputs
        pend_i = 32'h0000_0800; en_i = ALL; deleg_i = '0; priv_i = 2'b11; mstatus_mie_i = 1'b1;
        @(negedge clk);
        check("R6 settled", 1'b1, 5'd11);
        pend_i = 32'h0000_0008;
        #1;
        check("R6 before edge", 1'b1, 5'd11);
        @(negedge clk);
        check("R6 after edge", 1'b1, 5'd3);

        // R7: register write pulse withholds one cycle, then re-evaluates
        csr_wr_i = 1'b1;
        pend_i   = 32'h0000_0080;
        @(negedge clk);
        check("R7 withhold csr write", 1'b0, '0);
        csr_wr_i = 1'b0;
        @(negedge clk);
        check("R7 re-evaluate", 1'b1, 5'd7);
        xret_i = 1'b1;
        @(negedge clk);
        check("R7 withhold xret", 1'b0, '0);
        xret_i = 1'b0;
        mstatus_mie_i = 1'b0;
        @(negedge clk);
        check("R2 R7 new status applied", 1'b0, '0);

        // R9: reset while trapping
        mstatus_mie_i = 1'b1;
        @(negedge clk);
        check("R1 trapping before reset", 1'b1, 5'd7);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run", 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 after reset release", 1'b1, 5'd7);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule